// File: doc/BRIEF.md
# Undefined Opcode Trap Controller

This block sits beside the fetch stage of an 8-bit processor whose instructions may begin with one or two prefix bytes. It follows the stream of opcode fetches and keeps track of whether the current byte comes after a single prefix or after a two-byte prefix. An external decoder flags each fetched byte as defined or undefined. When a flagged byte is the second or third opcode byte of a prefixed instruction, the block raises a trap. It records which of the two positions faulted and takes control of the core for three cycles. In those cycles it writes the program counter to the stack, high byte first, lowers the stack pointer by two and reloads the program counter with zero.

A trap and a reset both restart at address zero. For this reason the block keeps a sticky trap status bit that only reset or a software write of zero clears. A second status bit holds the faulting position. With it, software can compute where the bad instruction began: stacked PC minus one for a second-byte fault, minus two for a third-byte fault. A combinational hit signal is raised in the same cycle as the faulting fetch, so the core can suppress every side effect of that byte.

Top module: `undef_trap_ctl`

## Requirements
- R1: After reset, trap_flag, ufo_flag, busy, stk_we, sp_load and pc_load are all 0.
- R2: A fetch with the undefined flag set, immediately following a fetch of one of the prefix bytes CBh, DDh, EDh or FDh, is a trap. In that case trap_hit is 1 combinationally in the same cycle, and from the next cycle trap_flag is 1 and ufo_flag is 0.
- R3: DDh then CBh, or FDh then CBh, forms a double prefix. An undefined flag on the next fetch traps and sets ufo_flag to 1.
- R4: The undefined flag has no effect on a fetch that does not follow a prefix. trap_hit stays 0 and no push starts.
- R5: After a prefix, any byte other than the CBh that completes a double prefix returns tracking to idle. This includes CBh after CBh or EDh, and any byte after a double prefix. An undefined flag on the following fetch then does not trap.
- R6: In the first cycle after a trap, stk_we writes PC[15:8] to SP-1. In the second it writes PC[7:0] to SP-2, with sp_load=1 and sp_next=SP-2. In the third, pc_load=1 and pc_next=0. PC and SP are those sampled with the faulting fetch, and all arithmetic is modulo 2^16.
- R7: busy is 1 for exactly those three cycles. Opcode-fetch strobes while busy are ignored: they neither trap nor change prefix tracking.
- R8: A software write with sts_wdata=0 clears trap_flag. A write with sts_wdata=1 leaves trap_flag unchanged. A trap in the same cycle as a clearing write wins.
- R9: ufo_flag keeps its value until the next trap or reset, and is unaffected by status writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Opcode-fetch strobe |
| fetch_byte | input | 8 | Fetched opcode byte |
| fetch_undef | input | 1 | Decoder flag: fetched byte is undefined |
| pc_in | input | 16 | Program counter to stack on a trap |
| sp_in | input | 16 | Current stack pointer |
| sts_wr | input | 1 | Software write to the trap status bit |
| sts_wdata | input | 1 | Value written; only 0 acts |
| trap_hit | output | 1 | Current fetch traps (suppress its execution) |
| busy | output | 1 | Push sequence in progress |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| sp_load | output | 1 | Load sp_next into SP |
| sp_next | output | 16 | New stack pointer |
| pc_load | output | 1 | Load pc_next into PC (restart fetch) |
| pc_next | output | 16 | Restart address |
| trap_flag | output | 1 | Sticky trap status bit |
| ufo_flag | output | 1 | 0: second byte faulted, 1: third byte faulted |

## Verification
The bench builds the block with its default 16-bit address and 8-bit byte widths, which keeps the whole byte space within reach of a sweep. For each of the four prefixes it tries every following byte twice: once flagged undefined, which must trap at the second position, and once defined, followed by an undefined fetch that must trap at the third position exactly when a double prefix was formed. Each trap is checked through the whole push sequence with PC and SP taken from the sweep indices, and a stack pointer of 0001h exercises address wrap. Targeted cases cover strobes during busy, the clear/set race on the status bit, and ufo_flag retention.

// File: rtl/utrap_pkg.sv
package utrap_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_BITS = 8'hCB;
  localparam logic [BYTE_W-1:0] OP_IXP  = 8'hDD;
  localparam logic [BYTE_W-1:0] OP_EXTP = 8'hED;
  localparam logic [BYTE_W-1:0] OP_IYP  = 8'hFD;

  typedef enum logic [1:0] {PF_IDLE, PF_ONE, PF_TWO} pfx_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HI, SQ_LO, SQ_RST} seq_e;

  function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
    return (b == OP_BITS) || (b == OP_IXP) || (b == OP_EXTP) || (b == OP_IYP);
  endfunction

  function automatic logic is_index(input logic [BYTE_W-1:0] b);
    return (b == OP_IXP) || (b == OP_IYP);
  endfunction

endpackage

// File: rtl/utrap_prefix_track.sv
module utrap_prefix_track
  import utrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              fetch_vld,
  input  logic [BYTE_W-1:0] fetch_byte,
  input  logic              fetch_undef,
  output logic              trap_hit,
  output logic              trap_third
);

  pfx_e st;
  logic idx_seen;
  logic fetch_ok;

  assign fetch_ok   = fetch_vld && !busy;
  assign trap_hit   = fetch_ok && fetch_undef && (st != PF_IDLE);
  assign trap_third = (st == PF_TWO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PF_IDLE;
      idx_seen <= 1'b0;
    end else if (fetch_ok) begin
      unique case (st)
        PF_IDLE: begin
          if (is_prefix(fetch_byte)) begin
            st       <= PF_ONE;
            idx_seen <= is_index(fetch_byte);
          end
        end
        PF_ONE: begin
          if (!fetch_undef && idx_seen && fetch_byte == OP_BITS) st <= PF_TWO;
          else                                                  st <= PF_IDLE;
        end
        default: st <= PF_IDLE;
      endcase
    end
  end

  // R7
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == PF_IDLE && !trap_hit));

  // R5
  third_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_TWO && fetch_ok) |=> (st == PF_IDLE));

endmodule

// File: rtl/utrap_stack_push.sv
module utrap_stack_push
  import utrap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_next,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next
);

  localparam logic [ADDR_W-1:0] RESTART_ADDR = '0;

  function automatic logic [ADDR_W-1:0] sp_minus(input logic [ADDR_W-1:0] sp,
                                                 input int unsigned n);
    return sp - ADDR_W'(n);
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(input logic [ADDR_W-1:0] v);
    return BYTE_W'(v >> BYTE_W);
  endfunction

  seq_e              sq;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq   <= SQ_IDLE;
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      unique case (sq)
        SQ_IDLE: if (start) begin
          sq   <= SQ_HI;
          pc_q <= pc_in;
          sp_q <= sp_in;
        end
        SQ_HI:   sq <= SQ_LO;
        SQ_LO:   sq <= SQ_RST;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (sq != SQ_IDLE);
  assign stk_we    = (sq == SQ_HI) || (sq == SQ_LO);
  assign stk_addr  = (sq == SQ_LO) ? sp_minus(sp_q, 2) : sp_minus(sp_q, 1);
  assign stk_wdata = (sq == SQ_LO) ? pc_q[BYTE_W-1:0] : hi_byte(pc_q);
  assign sp_load   = (sq == SQ_LO);
  assign sp_next   = sp_minus(sp_q, 2);
  assign pc_load   = (sq == SQ_RST);
  assign pc_next   = RESTART_ADDR;

  // R6
  low_below_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq == SQ_HI) |=> (stk_we && sp_load && stk_addr == $past(stk_addr) - 1'b1));

  // R6
  reload_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (pc_load && !stk_we));

  // R7
  release_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  // R7
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && stk_we && !sp_load));

endmodule

// File: rtl/undef_trap_ctl.sv
module undef_trap_ctl
  import utrap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [7:0]        fetch_byte,
  input  logic              fetch_undef,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              sts_wr,
  input  logic              sts_wdata,
  output logic              trap_hit,
  output logic              busy,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [7:0]        stk_wdata,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_next,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next,
  output logic              trap_flag,
  output logic              ufo_flag
);

  logic trap_third;
  logic sw_clear;

  utrap_prefix_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .fetch_vld  (fetch_vld),
    .fetch_byte (fetch_byte),
    .fetch_undef(fetch_undef),
    .trap_hit   (trap_hit),
    .trap_third (trap_third)
  );

  utrap_stack_push #(.ADDR_W(ADDR_W)) u_push (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (trap_hit),
    .pc_in    (pc_in),
    .sp_in    (sp_in),
    .busy     (busy),
    .stk_we   (stk_we),
    .stk_addr (stk_addr),
    .stk_wdata(stk_wdata),
    .sp_load  (sp_load),
    .sp_next  (sp_next),
    .pc_load  (pc_load),
    .pc_next  (pc_next)
  );

  assign sw_clear = sts_wr && !sts_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_flag <= 1'b0;
      ufo_flag  <= 1'b0;
    end else begin
      if (trap_hit) begin
        trap_flag <= 1'b1;
        ufo_flag  <= trap_third;
      end else if (sw_clear) begin
        trap_flag <= 1'b0;
      end
    end
  end

  // R2
  trap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> (trap_flag && busy));

  // R8
  set_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata && !trap_hit) |=> $stable(trap_flag));

  // R9
  ufo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_hit |=> $stable(ufo_flag));

  // R8
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !trap_hit) |=> !trap_flag);

endmodule

// File: tb/undef_trap_ctl_bench.sv
module undef_trap_ctl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [7:0]  fetch_byte = '0;
  logic        fetch_undef = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] sp_in = '0;
  logic        sts_wr = 1'b0;
  logic        sts_wdata = 1'b0;
  logic        trap_hit, busy, stk_we, sp_load, pc_load, trap_flag, ufo_flag;
  logic [15:0] stk_addr, sp_next, pc_next;
  logic [7:0]  stk_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  undef_trap_ctl u_undef_trap_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_byte(fetch_byte),
    .fetch_undef(fetch_undef), .pc_in(pc_in), .sp_in(sp_in), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .trap_hit(trap_hit), .busy(busy), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp_load(sp_load),
    .sp_next(sp_next), .pc_load(pc_load), .pc_next(pc_next),
    .trap_flag(trap_flag), .ufo_flag(ufo_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One fetch; checks the same-cycle hit before the edge.
  task automatic fetch(input logic [7:0] b, input logic u, input logic exp_hit,
                       input string req);
    fetch_vld = 1'b1; fetch_byte = b; fetch_undef = u;
    #2;
    chk(req, {31'd0, trap_hit}, {31'd0, exp_hit});
    step();
    fetch_vld = 1'b0; fetch_undef = 1'b0;
  endtask

  // Called right after the trapping edge.
  task automatic push_check(input logic [15:0] pc, input logic [15:0] sp,
                            input logic ufo);
    logic [15:0] a1, a2;
    a1 = sp - 16'd1;
    a2 = sp - 16'd2;
    chk("R2 trap_flag", {31'd0, trap_flag}, 32'd1);
    chk("R3 ufo_flag", {31'd0, ufo_flag}, {31'd0, ufo});
    chk("R6 hi write", {14'd0, busy, stk_we, stk_addr}, {14'd0, 1'b1, 1'b1, a1});
    chk("R6 hi data", {24'd0, stk_wdata}, {24'd0, pc[15:8]});
    step();
    chk("R6 lo write", {14'd0, busy, stk_we, stk_addr}, {14'd0, 1'b1, 1'b1, a2});
    chk("R6 lo data/sp", {7'd0, sp_load, stk_wdata, sp_next}, {7'd0, 1'b1, pc[7:0], a2});
    step();
    chk("R6 restart", {14'd0, busy, pc_load, pc_next}, {14'd0, 1'b1, 1'b1, 16'd0});
    chk("R7 no write in restart", {31'd0, stk_we}, 32'd0);
    step();
    chk("R7 busy released", {29'd0, busy, pc_load, stk_we}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pfx [4];
    pfx[0] = 8'hCB; pfx[1] = 8'hDD; pfx[2] = 8'hED; pfx[3] = 8'hFD;

    step(); step();
    // R1 reset state
    chk("R1 reset outputs", {26'd0, trap_flag, ufo_flag, busy, stk_we, sp_load, pc_load}, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", {26'd0, trap_flag, ufo_flag, busy, stk_we, sp_load, pc_load}, 32'd0);

    // R4: undefined flag on unprefixed bytes
    for (int b = 0; b < 256; b += 17) begin
      if (b == 8'hCB || b == 8'hDD || b == 8'hED || b == 8'hFD) continue;
      fetch(8'(b), 1'b1, 1'b0, "R4 unprefixed undef");
      chk("R4 no push", {30'd0, busy, trap_flag}, 32'd0);
    end

    // R2/R3/R5 sweep
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 256; b++) begin
        logic dbl;
        pc_in = {6'(p), 2'b01, 8'(b)};
        sp_in = (b == 0) ? 16'h0001 : {8'(b), 8'h40};
        // second byte undefined
        fetch(pfx[p], 1'b0, 1'b0, "R4 prefix itself");
        fetch(8'(b), 1'b1, 1'b1, "R2 second-byte trap");
        push_check(pc_in, sp_in, 1'b0);
        // second byte defined, then an undefined fetch
        dbl = (p == 1 || p == 3) && b == 8'hCB;
        fetch(pfx[p], 1'b0, 1'b0, "R4 prefix itself");
        fetch(8'(b), 1'b0, 1'b0, "R5 defined second byte");
        fetch(8'h76, 1'b1, dbl, dbl ? "R3 third-byte trap" : "R5 tracking idle");
        if (dbl) push_check(pc_in, sp_in, 1'b1);
        else chk("R5 no push", {31'd0, busy}, 32'd0);
        // R5: after the third byte, tracking is idle again
        if (dbl) begin
          fetch(pfx[p], 1'b0, 1'b0, "R4 prefix itself");
          fetch(8'hCB, 1'b0, 1'b0, "R3 double prefix");
          fetch(8'h07, 1'b0, 1'b0, "R5 defined third byte");
          fetch(8'h07, 1'b1, 1'b0, "R5 idle after third");
        end
      end
    end

    // R7: strobes while busy are ignored
    pc_in = 16'h1234; sp_in = 16'h8000;
    fetch(8'hED, 1'b0, 1'b0, "R4 prefix itself");
    fetch(8'hFF, 1'b1, 1'b1, "R2 trap");
    fetch_vld = 1'b1; fetch_byte = 8'hDD; fetch_undef = 1'b1;
    #2;
    chk("R7 no hit while busy", {31'd0, trap_hit}, 32'd0);
    step();
    fetch_byte = 8'hCB;
    #2;
    chk("R7 no hit while busy", {31'd0, trap_hit}, 32'd0);
    step();
    fetch_vld = 1'b0; fetch_undef = 1'b0;
    chk("R7 restart cycle", {31'd0, pc_load}, 32'd1);
    step();
    chk("R7 busy done", {31'd0, busy}, 32'd0);
    fetch(8'h00, 1'b1, 1'b0, "R7 busy strobes left no prefix");

    // R8: status writes
    sts_wr = 1'b1; sts_wdata = 1'b1;
    step();
    sts_wr = 1'b0;
    chk("R8 write 1 ignored", {31'd0, trap_flag}, 32'd1);
    sts_wr = 1'b1; sts_wdata = 1'b0;
    step();
    sts_wr = 1'b0;
    chk("R8 write 0 clears", {31'd0, trap_flag}, 32'd0);
    chk("R9 ufo kept on write", {31'd0, ufo_flag}, 32'd0);
    // trap wins over simultaneous clear
    fetch(8'hFD, 1'b0, 1'b0, "R4 prefix itself");
    fetch(8'hCB, 1'b0, 1'b0, "R3 double prefix");
    sts_wr = 1'b1; sts_wdata = 1'b0;
    fetch(8'h99, 1'b1, 1'b1, "R3 trap");
    sts_wr = 1'b0;
    chk("R8 trap beats clear", {31'd0, trap_flag}, 32'd1);
    chk("R3 ufo set", {31'd0, ufo_flag}, 32'd1);
    step(); step(); step();
    // R9: ufo survives clears and untrapped fetches
    sts_wr = 1'b1; sts_wdata = 1'b0;
    step();
    sts_wr = 1'b0;
    fetch(8'h00, 1'b1, 1'b0, "R4 unprefixed undef");
    chk("R9 ufo retained", {30'd0, trap_flag, ufo_flag}, 32'd1);

    // R1: reset clears sticky bits
    rst_n = 1'b0;
    step();
    chk("R1 reset clears status", {30'd0, trap_flag, ufo_flag}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule